// File: doc/BRIEF.md
# Mode-Banked Register File

This block keeps the sixteen 32-bit general registers of a processor core together with the shadow copies that belong to its privileged modes. Reads and writes from the datapath always see the copies that belong to the current mode. A single mode-change request moves the outgoing mode's copies into storage and brings the incoming mode's copies into view.

The current mode is held in a small state machine. Its seven states are USR (10000), FIQ (10001), IRQ (10010), SVC (10011), ABT (10111), UND (11011) and SYS (11111). Reset enters SYS. It has two transitions. A request carrying one of the seven codes moves to that state at the next edge, and this happens even when the code names the current mode. A request carrying any other code, or no request at all, keeps the state. A user-view port lets privileged code read and write the user-mode copies of the banked registers without leaving its own mode.

Top module: `banked_regfile`

## Requirements
- R1: After reset `cur_mode` reads 11111 (SYS), every register and every shadow copy is zero, `spsr_rd_data` is zero and `mode_err` is low.
- R2: Both read ports are combinational from the live registers. A write through `wr_en` lands at the next clock edge, so a read in the write cycle returns the old value.
- R3: A request with a legal code (USR 10000, FIQ 10001, IRQ 10010, SVC 10011, ABT 10111, UND 11011, SYS 11111) sets `cur_mode` to that code at the next edge. Reads in the request cycle still return the outgoing mode's values.
- R4: A request with any other code raises `mode_err` for exactly the next cycle. It leaves the mode and all register contents unchanged.
- R5: r13 and r14 have six copies: one shared by USR and SYS, and one each for FIQ, IRQ, SVC, ABT and UND.
- R6: r8 to r12 have two copies: one for FIQ and one shared by all other modes.
- R7: Each of FIQ, IRQ, SVC, ABT and UND has its own saved status word, read through `spsr_rd_data` and written through `spsr_wr_en`. In USR and SYS the word reads zero and writes are ignored.
- R8: r0 to r7 and r15 are never swapped by a mode change.
- R9: The user-view port reaches the non-FIQ copy of r8 to r12 while in FIQ, and the USR/SYS copy of r13/r14 while in any mode other than USR or SYS. Every other index reaches the live register. A user-view write to a shadow copy leaves the live register unchanged.
- R10: A register or status write in the same cycle as a legal mode request is applied to the outgoing mode's copy before the swap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rd_idx_a | input | 4 | Read port A index |
| rd_data_a | output | 32 | Read port A data |
| rd_idx_b | input | 4 | Read port B index |
| rd_data_b | output | 32 | Read port B data |
| wr_en | input | 1 | Write strobe, current mode |
| wr_idx | input | 4 | Write index |
| wr_data | input | 32 | Write data |
| uv_rd_idx | input | 4 | User-view read index |
| uv_rd_data | output | 32 | User-view read data |
| uv_wr_en | input | 1 | User-view write strobe |
| uv_wr_idx | input | 4 | User-view write index |
| uv_wr_data | input | 32 | User-view write data |
| spsr_wr_en | input | 1 | Saved status write strobe |
| spsr_wr_data | input | 32 | Saved status write data |
| spsr_rd_data | output | 32 | Saved status word of current mode |
| mode_req | input | 1 | Mode-change request |
| mode_new | input | 5 | Requested mode code |
| cur_mode | output | 5 | Current mode code |
| mode_err | output | 1 | Illegal mode code seen last cycle |

## Verification
The properties assume that `mode_new` only matters while `mode_req` is high. They also assume that a register written through `wr_en` without a mode request holds its value one cycle later, unless a user-view write to the same live index arrives in that cycle. To stay inside these assumptions, the stimulus raises every strobe for one cycle only, between falling edges, and never pairs a user-view write with a normal write to the same register. Illegal codes are sent only as single requests, so each one can be seen to leave the mode unchanged.

// File: rtl/bankrf_pkg.sv
package bankrf_pkg;

    localparam int XLEN   = 32;
    localparam int NREG   = 16;
    localparam int AW     = $clog2(NREG);
    localparam int HI_LO  = 8;
    localparam int HI_N   = 5;
    localparam int SP_IX  = 13;
    localparam int LR_IX  = 14;
    localparam int NSTACK = 6;
    localparam int NSAVED = 5;

    typedef enum logic [4:0] {
        M_USR = 5'b10000,
        M_FIQ = 5'b10001,
        M_IRQ = 5'b10010,
        M_SVC = 5'b10011,
        M_ABT = 5'b10111,
        M_UND = 5'b11011,
        M_SYS = 5'b11111
    } mode_e;

    typedef enum logic [1:0] {VT_LIVE, VT_HI, VT_SP, VT_LR} view_e;

    function automatic logic code_legal(logic [4:0] c);
        return c == M_USR || c == M_FIQ || c == M_IRQ || c == M_SVC ||
               c == M_ABT || c == M_UND || c == M_SYS;
    endfunction

    function automatic logic [2:0] stack_slot(mode_e m);
        case (m)
            M_SVC:   return 3'd1;
            M_ABT:   return 3'd2;
            M_UND:   return 3'd3;
            M_IRQ:   return 3'd4;
            M_FIQ:   return 3'd5;
            default: return 3'd0;
        endcase
    endfunction

    function automatic logic has_saved(mode_e m);
        return !(m == M_USR || m == M_SYS);
    endfunction

    function automatic logic [2:0] saved_slot(mode_e m);
        case (m)
            M_ABT:   return 3'd1;
            M_UND:   return 3'd2;
            M_IRQ:   return 3'd3;
            M_FIQ:   return 3'd4;
            default: return 3'd0;
        endcase
    endfunction

    function automatic logic hi_sel(mode_e m);
        return m == M_FIQ;
    endfunction

    function automatic view_e view_of(mode_e m, logic [AW-1:0] idx);
        if (m == M_FIQ && idx >= AW'(HI_LO) && idx < AW'(HI_LO + HI_N)) return VT_HI;
        if (has_saved(m) && idx == AW'(SP_IX)) return VT_SP;
        if (has_saved(m) && idx == AW'(LR_IX)) return VT_LR;
        return VT_LIVE;
    endfunction

endpackage

// File: rtl/bankrf_mode_fsm.sv
module bankrf_mode_fsm
    import bankrf_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req,
    input  logic [4:0] req_code,
    output mode_e      cur,
    output mode_e      nxt,
    output logic       swap,
    output logic       err
);
    mode_e state_q;
    mode_e state_d;
    logic  bad;
    logic  err_q;

    always_comb begin
        state_d = state_q;
        bad     = 1'b0;
        if (req) begin
            unique case (req_code)
                M_USR:   state_d = M_USR;
                M_FIQ:   state_d = M_FIQ;
                M_IRQ:   state_d = M_IRQ;
                M_SVC:   state_d = M_SVC;
                M_ABT:   state_d = M_ABT;
                M_UND:   state_d = M_UND;
                M_SYS:   state_d = M_SYS;
                default: bad = 1'b1;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= M_SYS;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) err_q <= 1'b0;
        else        err_q <= req && bad;
    end

    assign cur  = state_q;
    assign nxt  = state_d;
    assign swap = req && !bad;
    assign err  = err_q;
endmodule

// File: rtl/bankrf_store.sv
module bankrf_store
    import bankrf_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst_n,
    input  mode_e                     cur,
    input  mode_e                     nxt,
    input  logic                      swap,
    input  logic                      wr_en,
    input  logic [AW-1:0]             wr_idx,
    input  logic [XLEN-1:0]           wr_data,
    input  logic                      uw_en,
    input  logic [AW-1:0]             uw_idx,
    input  logic [XLEN-1:0]           uw_data,
    input  logic [AW-1:0]             ur_idx,
    output logic [XLEN-1:0]           ur_data,
    input  logic                      sv_we,
    input  logic [XLEN-1:0]           sv_wd,
    output logic [XLEN-1:0]           sv_rd,
    output logic [NREG-1:0][XLEN-1:0] live_o
);
    logic [NREG-1:0][XLEN-1:0]        live_q, live_d;
    logic [NSTACK-1:0][XLEN-1:0]      sp_q, sp_d, lr_q, lr_d;
    logic [1:0][HI_N-1:0][XLEN-1:0]   hi_q, hi_d;
    logic [XLEN-1:0]                  sv_q, sv_d;
    logic [NSAVED-1:0][XLEN-1:0]      sb_q, sb_d;

    view_e      uw_view, ur_view;
    logic [2:0] uw_off, ur_off;

    assign uw_view = view_of(cur, uw_idx);
    assign ur_view = view_of(cur, ur_idx);
    assign uw_off  = 3'(uw_idx - AW'(HI_LO));
    assign ur_off  = 3'(ur_idx - AW'(HI_LO));

    always_comb begin
        live_d = live_q;
        sp_d   = sp_q;
        lr_d   = lr_q;
        hi_d   = hi_q;
        sv_d   = sv_q;
        sb_d   = sb_q;
        if (uw_en) begin
            unique case (uw_view)
                VT_HI:   hi_d[0][uw_off] = uw_data;
                VT_SP:   sp_d[0] = uw_data;
                VT_LR:   lr_d[0] = uw_data;
                default: live_d[uw_idx] = uw_data;
            endcase
        end
        if (wr_en) live_d[wr_idx] = wr_data;
        if (sv_we && has_saved(cur)) sv_d = sv_wd;
        if (swap) begin
            for (int k = 0; k < HI_N; k++) hi_d[hi_sel(cur)][k] = live_d[HI_LO + k];
            sp_d[stack_slot(cur)] = live_d[SP_IX];
            lr_d[stack_slot(cur)] = live_d[LR_IX];
            if (has_saved(cur)) sb_d[saved_slot(cur)] = sv_d;
            for (int k = 0; k < HI_N; k++) live_d[HI_LO + k] = hi_d[hi_sel(nxt)][k];
            live_d[SP_IX] = sp_d[stack_slot(nxt)];
            live_d[LR_IX] = lr_d[stack_slot(nxt)];
            sv_d = has_saved(nxt) ? sb_d[saved_slot(nxt)] : '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            live_q <= '0;
            sp_q   <= '0;
            lr_q   <= '0;
            hi_q   <= '0;
            sv_q   <= '0;
            sb_q   <= '0;
        end else begin
            live_q <= live_d;
            sp_q   <= sp_d;
            lr_q   <= lr_d;
            hi_q   <= hi_d;
            sv_q   <= sv_d;
            sb_q   <= sb_d;
        end
    end

    always_comb begin
        unique case (ur_view)
            VT_HI:   ur_data = hi_q[0][ur_off];
            VT_SP:   ur_data = sp_q[0];
            VT_LR:   ur_data = lr_q[0];
            default: ur_data = live_q[ur_idx];
        endcase
    end

    assign sv_rd  = sv_q;
    assign live_o = live_q;
endmodule

// File: rtl/bankrf_rdmux.sv
module bankrf_rdmux
    import bankrf_pkg::*;
#(
    parameter int NPORT = 2
) (
    input  logic [NREG-1:0][XLEN-1:0]  live,
    input  logic [NPORT-1:0][AW-1:0]   idx,
    output logic [NPORT-1:0][XLEN-1:0] data
);
    for (genvar p = 0; p < NPORT; p++) begin : g_port
        assign data[p] = live[idx[p]];
    end
endmodule

// File: rtl/banked_regfile.sv
module banked_regfile
    import bankrf_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [AW-1:0]   rd_idx_a,
    output logic [XLEN-1:0] rd_data_a,
    input  logic [AW-1:0]   rd_idx_b,
    output logic [XLEN-1:0] rd_data_b,
    input  logic            wr_en,
    input  logic [AW-1:0]   wr_idx,
    input  logic [XLEN-1:0] wr_data,
    input  logic [AW-1:0]   uv_rd_idx,
    output logic [XLEN-1:0] uv_rd_data,
    input  logic            uv_wr_en,
    input  logic [AW-1:0]   uv_wr_idx,
    input  logic [XLEN-1:0] uv_wr_data,
    input  logic            spsr_wr_en,
    input  logic [XLEN-1:0] spsr_wr_data,
    output logic [XLEN-1:0] spsr_rd_data,
    input  logic            mode_req,
    input  logic [4:0]      mode_new,
    output logic [4:0]      cur_mode,
    output logic            mode_err
);
    localparam int NPORT = 2;

    mode_e                       cur, nxt;
    logic                        swap;
    logic [NREG-1:0][XLEN-1:0]   live;
    logic [NPORT-1:0][AW-1:0]    rix;
    logic [NPORT-1:0][XLEN-1:0]  rdat;

    bankrf_mode_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .req(mode_req), .req_code(mode_new),
        .cur(cur), .nxt(nxt), .swap(swap), .err(mode_err)
    );

    bankrf_store u_store (
        .clk(clk), .rst_n(rst_n), .cur(cur), .nxt(nxt), .swap(swap),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .uw_en(uv_wr_en), .uw_idx(uv_wr_idx), .uw_data(uv_wr_data),
        .ur_idx(uv_rd_idx), .ur_data(uv_rd_data),
        .sv_we(spsr_wr_en), .sv_wd(spsr_wr_data), .sv_rd(spsr_rd_data),
        .live_o(live)
    );

    assign rix = {rd_idx_b, rd_idx_a};

    bankrf_rdmux #(.NPORT(NPORT)) u_rd (
        .live(live), .idx(rix), .data(rdat)
    );

    assign rd_data_a = rdat[0];
    assign rd_data_b = rdat[1];
    assign cur_mode  = cur;
endmodule

// File: rtl/bankrf_chk.sv
module bankrf_chk
    import bankrf_pkg::*;
(
    input logic            clk,
    input logic            rst_n,
    input logic            mode_req,
    input logic [4:0]      mode_new,
    input logic [4:0]      cur_mode,
    input logic            mode_err,
    input logic [XLEN-1:0] spsr_rd_data,
    input logic            wr_en,
    input logic [AW-1:0]   wr_idx,
    input logic [XLEN-1:0] wr_data,
    input logic [AW-1:0]   rd_idx_a,
    input logic [XLEN-1:0] rd_data_a
);
    p_legal_state_r3: assert property (@(posedge clk) disable iff (!rst_n)
        code_legal(cur_mode));

    p_take_mode_r3: assert property (@(posedge clk) disable iff (!rst_n)
        mode_req && code_legal(mode_new) |=> cur_mode == $past(mode_new));

    p_reject_mode_r4: assert property (@(posedge clk) disable iff (!rst_n)
        mode_req && !code_legal(mode_new) |=> mode_err && $stable(cur_mode));

    p_err_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(mode_req && !code_legal(mode_new)) |=> !mode_err);

    p_no_saved_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_mode == M_USR || cur_mode == M_SYS) |-> spsr_rd_data == '0);

    p_write_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && !mode_req |=> rd_idx_a != $past(wr_idx) || rd_data_a == $past(wr_data));
endmodule

bind banked_regfile bankrf_chk u_chk (
    .clk(clk), .rst_n(rst_n), .mode_req(mode_req), .mode_new(mode_new),
    .cur_mode(cur_mode), .mode_err(mode_err), .spsr_rd_data(spsr_rd_data),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .rd_idx_a(rd_idx_a), .rd_data_a(rd_data_a)
);

// File: tb/test_banked_regfile.sv
module test_banked_regfile;
    localparam int CLK_PERIOD = 10;
    localparam int NSTEP = 28;

    typedef struct packed {
        logic [2:0]  op;
        logic [3:0]  idx;
        logic [31:0] val;
        logic [4:0]  chk;
        logic [31:0] exp;
    } step_t;

    localparam logic [2:0] OP_WR = 3'd0, OP_MODE = 3'd1, OP_UW = 3'd2, OP_SV = 3'd3, OP_NOP = 3'd4;
    localparam logic [4:0] C_SV = 5'd16, C_MODE = 5'd17;

    localparam step_t TAB [NSTEP] = '{
        '{OP_WR,   4'd13, 32'h1300,     5'd13,  32'h1300},
        '{OP_WR,   4'd8,  32'h0800,     5'd8,   32'h0800},
        '{OP_MODE, 4'd0,  32'h11,       5'd13,  32'h0},
        '{OP_NOP,  4'd0,  32'h0,        5'd8,   32'h0},
        '{OP_WR,   4'd8,  32'h8F,       5'd8,   32'h8F},
        '{OP_WR,   4'd13, 32'hF13,      5'd13,  32'hF13},
        '{OP_SV,   4'd0,  32'hF0000011, C_SV,   32'hF0000011},
        '{OP_MODE, 4'd0,  32'h12,       5'd8,   32'h0800},
        '{OP_NOP,  4'd0,  32'h0,        5'd13,  32'h0},
        '{OP_NOP,  4'd0,  32'h0,        C_SV,   32'h0},
        '{OP_WR,   4'd13, 32'h1213,     5'd13,  32'h1213},
        '{OP_MODE, 4'd0,  32'h13,       5'd13,  32'h0},
        '{OP_MODE, 4'd0,  32'h11,       5'd13,  32'hF13},
        '{OP_NOP,  4'd0,  32'h0,        5'd8,   32'h8F},
        '{OP_NOP,  4'd0,  32'h0,        C_SV,   32'hF0000011},
        '{OP_MODE, 4'd0,  32'h10,       5'd13,  32'h1300},
        '{OP_NOP,  4'd0,  32'h0,        5'd8,   32'h0800},
        '{OP_NOP,  4'd0,  32'h0,        C_SV,   32'h0},
        '{OP_SV,   4'd0,  32'h12345678, C_SV,   32'h0},
        '{OP_MODE, 4'd0,  32'h12,       5'd13,  32'h1213},
        '{OP_MODE, 4'd0,  32'h1F,       5'd13,  32'h1300},
        '{OP_WR,   4'd3,  32'h33,       5'd3,   32'h33},
        '{OP_MODE, 4'd0,  32'h1B,       5'd3,   32'h33},
        '{OP_MODE, 4'd0,  32'h17,       C_MODE, 32'h17},
        '{OP_MODE, 4'd0,  32'h15,       C_MODE, 32'h17},
        '{OP_WR,   4'd14, 32'hAB14,     5'd14,  32'hAB14},
        '{OP_MODE, 4'd0,  32'h1F,       5'd14,  32'h0},
        '{OP_MODE, 4'd0,  32'h17,       5'd14,  32'hAB14}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  rd_idx_a = '0, rd_idx_b = '0, wr_idx = '0, uv_rd_idx = '0, uv_wr_idx = '0;
    logic [31:0] rd_data_a, rd_data_b, uv_rd_data, spsr_rd_data;
    logic        wr_en = 1'b0, uv_wr_en = 1'b0, spsr_wr_en = 1'b0, mode_req = 1'b0;
    logic [31:0] wr_data = '0, uv_wr_data = '0, spsr_wr_data = '0;
    logic [4:0]  mode_new = '0, cur_mode;
    logic        mode_err;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    banked_regfile i_banked_regfile (
        .clk(clk), .rst_n(rst_n),
        .rd_idx_a(rd_idx_a), .rd_data_a(rd_data_a),
        .rd_idx_b(rd_idx_b), .rd_data_b(rd_data_b),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .uv_rd_idx(uv_rd_idx), .uv_rd_data(uv_rd_data),
        .uv_wr_en(uv_wr_en), .uv_wr_idx(uv_wr_idx), .uv_wr_data(uv_wr_data),
        .spsr_wr_en(spsr_wr_en), .spsr_wr_data(spsr_wr_data), .spsr_rd_data(spsr_rd_data),
        .mode_req(mode_req), .mode_new(mode_new), .cur_mode(cur_mode), .mode_err(mode_err)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic clear_strobes();
        wr_en = 1'b0; uv_wr_en = 1'b0; spsr_wr_en = 1'b0; mode_req = 1'b0;
    endtask

    task automatic req_mode(logic [4:0] code);
        mode_req = 1'b1; mode_new = code;
        @(negedge clk);
        clear_strobes();
    endtask

    task automatic reg_write(logic [3:0] idx, logic [31:0] val);
        wr_en = 1'b1; wr_idx = idx; wr_data = val;
        @(negedge clk);
        clear_strobes();
    endtask

    task automatic read_a(logic [3:0] idx, string req, logic [31:0] exp);
        rd_idx_a = idx;
        #1;
        check(req, rd_data_a, exp);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 mode", {27'd0, cur_mode}, 32'h1F);
        check("R1 err", {31'd0, mode_err}, 32'h0);
        check("R1 spsr", spsr_rd_data, 32'h0);
        read_a(4'd13, "R1 r13", 32'h0);

        // R2 read during write returns old value, port B too
        wr_en = 1'b1; wr_idx = 4'd5; wr_data = 32'h55; rd_idx_a = 4'd5; rd_idx_b = 4'd5;
        #1;
        check("R2 old a", rd_data_a, 32'h0);
        @(negedge clk);
        clear_strobes();
        #1;
        check("R2 new a", rd_data_a, 32'h55);
        check("R2 new b", rd_data_b, 32'h55);

        // table walk: R3 R5 R6 R7 R8
        for (int s = 0; s < NSTEP; s++) begin
            unique case (TAB[s].op)
                OP_WR:   begin wr_en = 1'b1; wr_idx = TAB[s].idx; wr_data = TAB[s].val; end
                OP_MODE: begin mode_req = 1'b1; mode_new = TAB[s].val[4:0]; end
                OP_UW:   begin uv_wr_en = 1'b1; uv_wr_idx = TAB[s].idx; uv_wr_data = TAB[s].val; end
                OP_SV:   begin spsr_wr_en = 1'b1; spsr_wr_data = TAB[s].val; end
                default: ;
            endcase
            @(negedge clk);
            clear_strobes();
            if (TAB[s].chk == C_SV)        check($sformatf("R7 step %0d", s), spsr_rd_data, TAB[s].exp);
            else if (TAB[s].chk == C_MODE) check($sformatf("R3 step %0d", s), {27'd0, cur_mode}, TAB[s].exp);
            else read_a(TAB[s].chk[3:0], $sformatf("R5 R6 R8 step %0d", s), TAB[s].exp);
        end

        // R9 user view from ABT
        uv_rd_idx = 4'd13;
        #1;
        check("R9 uv r13 from ABT", uv_rd_data, 32'h1300);
        uv_wr_en = 1'b1; uv_wr_idx = 4'd14; uv_wr_data = 32'h5555;
        @(negedge clk);
        clear_strobes();
        read_a(4'd14, "R9 live r14 untouched", 32'hAB14);
        req_mode(5'h1F);
        read_a(4'd14, "R9 user r14 written", 32'h5555);

        // R3 old values visible in the request cycle
        rd_idx_a = 4'd8; mode_req = 1'b1; mode_new = 5'h11;
        #1;
        check("R3 old r8 before edge", rd_data_a, 32'h0800);
        @(negedge clk);
        clear_strobes();
        read_a(4'd8, "R3 fiq r8 after edge", 32'h8F);

        // R9 user view inside FIQ
        uv_rd_idx = 4'd8;
        #1;
        check("R9 uv r8 from FIQ", uv_rd_data, 32'h0800);
        uv_rd_idx = 4'd3;
        #1;
        check("R9 uv r3 live", uv_rd_data, 32'h33);
        uv_wr_en = 1'b1; uv_wr_idx = 4'd9; uv_wr_data = 32'h99;
        @(negedge clk);
        clear_strobes();
        read_a(4'd9, "R9 fiq r9 untouched", 32'h0);
        req_mode(5'h1F);
        read_a(4'd9, "R9 user r9 written", 32'h99);

        // R10 write in the mode-change cycle lands in outgoing copy
        wr_en = 1'b1; wr_idx = 4'd13; wr_data = 32'hAAAA; mode_req = 1'b1; mode_new = 5'h13;
        @(negedge clk);
        clear_strobes();
        read_a(4'd13, "R10 svc r13", 32'h0);
        req_mode(5'h1F);
        read_a(4'd13, "R10 sys r13 kept write", 32'hAAAA);
        uv_rd_idx = 4'd13;
        #1;
        check("R9 uv r13 in SYS live", uv_rd_data, 32'hAAAA);

        // R4 illegal code
        req_mode(5'h00);
        check("R4 err raised", {31'd0, mode_err}, 32'h1);
        check("R4 mode kept", {27'd0, cur_mode}, 32'h1F);
        read_a(4'd13, "R4 regs kept", 32'hAAAA);
        @(negedge clk);
        check("R4 err one cycle", {31'd0, mode_err}, 32'h0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule